// File: doc/BRIEF.md
# Load/Store Memory Request Port

This block joins a load/store pipeline to a data memory that works with a request, grant and response-valid handshake. The pipeline offers one operation at a time through a valid/ready pair. Each operation is either a load or a store and carries a physical address, write data, byte enables and a transaction tag. The block registers the operation and raises a memory request, then holds every request field steady until the memory grants it.

A grant only means that the memory has taken the request. The answer comes on a separate read-valid strobe some cycles later, and stores are answered this way as well. Every granted operation therefore enters an in-order queue of tags and load/store flags. Each response pops the oldest entry and is reported with that entry's tag. A load response also carries the read data. A store response is a bare completion pulse.

Pipeline ready depends on the current grant, so a memory that grants in the same cycle keeps one operation moving per clock. When the queue has no room for another operation, ready drops and no new request is raised. A response that arrives while the queue is empty is reported on an error output.

Top module: `lsu_mem_port`

## Requirements
- R1: A synchronous active-high reset clears `mem_req`, `ld_valid`, `st_done`, `proto_err`, `ld_data` and `rsp_id` and empties the in-flight queue. While reset is held, `in_ready` reads 1 and no operation is accepted.
- R2: An operation is accepted in a cycle where `in_valid` and `in_ready` are both 1. In the next cycle `mem_req` is 1 and `mem_addr`, `mem_wdata`, `mem_be` and `mem_we` carry the accepted values. `mem_we` is 1 for a store (`in_store`=1) and 0 for a load.
- R3: While `mem_req` is 1 and `mem_gnt` is 0, the next cycle still has `mem_req` at 1 with `mem_addr`, `mem_we`, `mem_wdata` and `mem_be` unchanged. After a grant with no new acceptance, `mem_req` falls to 0 in the next cycle.
- R4: `in_ready` is 1 when no request is waiting for a grant, or when the waiting request is granted in the current cycle, provided the queue has room. With grants in the same cycle and one-cycle responses, one operation is accepted every cycle.
- R5: The queued entries plus any waiting request never exceed DEPTH. When they equal DEPTH, `in_ready` is 0, and no request is raised while the queue is full.
- R6: A `mem_rvalid` that pops a load entry produces, in the next cycle, `ld_valid`=1, `ld_data` equal to the `mem_rdata` of the response cycle, and `rsp_id` equal to that load's tag. Responses are matched to operations in grant order.
- R7: A `mem_rvalid` that pops a store entry produces, in the next cycle, `st_done`=1 and `rsp_id` equal to the store's tag. `ld_valid` stays 0, and `ld_data` keeps its previous value whatever `mem_rdata` carries.
- R8: A grant and a response in the same cycle push and pop the queue at once. Neither is lost, and tags keep their grant order.
- R9: A `mem_rvalid` while the queue is empty raises `proto_err` for one cycle in the next cycle and changes no other output. At most one of `ld_valid`, `st_done` and `proto_err` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Pipeline offers an operation |
| in_ready | output | 1 | Block accepts the offered operation this cycle |
| in_store | input | 1 | 1 = store, 0 = load |
| in_addr | input | ADDR_W | Physical address |
| in_wdata | input | DATA_W | Store data |
| in_be | input | DATA_W/8 | Byte enables |
| in_id | input | ID_W | Transaction tag |
| mem_req | output | 1 | Request to memory |
| mem_gnt | input | 1 | Memory takes the request |
| mem_addr | output | ADDR_W | Request address |
| mem_we | output | 1 | Write enable (store) |
| mem_wdata | output | DATA_W | Write data |
| mem_be | output | DATA_W/8 | Byte enables |
| mem_rvalid | input | 1 | Response for the oldest granted request |
| mem_rdata | input | DATA_W | Response data, meaningful for loads |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | DATA_W | Load result data |
| st_done | output | 1 | Store completion pulse |
| rsp_id | output | ID_W | Tag of the reported response |
| proto_err | output | 1 | Response arrived with nothing in flight |

## Verification
The bench builds the block with DEPTH=3 and ID_W=4. The odd depth makes the queue pointers wrap at a count that is not a power of two. The small depth lets long response delays fill the queue within a few cycles, so the full-queue stall of R5 occurs often. Other phases grant at once with one-cycle responses to exercise the one-per-cycle rate and simultaneous push/pop, apply spurious responses before and after a mid-flight reset, and run randomized grant and response delays.

// File: rtl/lsu_mem_pkg.sv
package lsu_mem_pkg;
  typedef enum logic {
    OP_LOAD  = 1'b0,
    OP_STORE = 1'b1
  } lsu_op_e;
endpackage

// File: rtl/lsu_req_reg.sv
// Holds one memory request until the memory grants it.
module lsu_req_reg #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BE_W   = 4,
  parameter int ID_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              gnt_i,
  input  logic              store_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [ID_W-1:0]   id_i,
  output logic              req_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [BE_W-1:0]   be_o,
  output logic [ID_W-1:0]   id_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req_o <= 1'b0;
    end else if (load_i) begin
      req_o <= 1'b1;
    end else if (gnt_i) begin
      req_o <= 1'b0;
    end
  end

  // payload carries no reset: it only matters while req_o is high
  always_ff @(posedge clk) begin
    if (load_i && !rst) begin
      we_o    <= store_i;
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
      be_o    <= be_i;
      id_o    <= id_i;
    end
  end

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (req_o && !gnt_i) |=> (req_o && $stable(addr_o) && $stable(we_o)
                           && $stable(wdata_o) && $stable(be_o)));
endmodule

// File: rtl/lsu_inflight_fifo.sv
// In-order queue of granted transactions; storage has no reset so it maps to RAM.
module lsu_inflight_fifo #(
  parameter int W     = 5,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [W-1:0]     store_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (push_i) store_q[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (pop_i)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o  = store_q[rd_ptr];
  assign empty_o = (cnt_q == '0);
  assign count_o = cnt_q;

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    push_i |-> (cnt_q != FULL_CNT));
  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    pop_i |-> !empty_o);
endmodule

// File: rtl/lsu_rsp_stage.sv
// Turns a memory response plus the popped queue entry into registered results.
module lsu_rsp_stage
  import lsu_mem_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ID_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rvalid_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              empty_i,
  input  logic [ID_W:0]     head_i,
  output logic              pop_o,
  output logic              ld_valid_o,
  output logic [DATA_W-1:0] ld_data_o,
  output logic              st_done_o,
  output logic [ID_W-1:0]   rsp_id_o,
  output logic              err_o
);
  lsu_op_e head_op;
  assign head_op = lsu_op_e'(head_i[ID_W]);
  assign pop_o   = rvalid_i && !empty_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_valid_o <= 1'b0;
      ld_data_o  <= '0;
      st_done_o  <= 1'b0;
      rsp_id_o   <= '0;
      err_o      <= 1'b0;
    end else begin
      ld_valid_o <= 1'b0;
      st_done_o  <= 1'b0;
      err_o      <= rvalid_i && empty_i;
      if (pop_o) begin
        rsp_id_o <= head_i[ID_W-1:0];
        if (head_op == OP_STORE) begin
          st_done_o <= 1'b1;
        end else begin
          ld_valid_o <= 1'b1;
          ld_data_o  <= rdata_i;
        end
      end
    end
  end

  // R9
  rsp_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ld_valid_o, st_done_o, err_o}));
  // R7
  store_keeps_data_chk: assert property (@(posedge clk) disable iff (rst)
    st_done_o |-> $stable(ld_data_o));
endmodule

// File: rtl/lsu_mem_port.sv
module lsu_mem_port #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int ID_W   = 4,
  parameter int DEPTH  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_store,
  input  logic [ADDR_W-1:0]   in_addr,
  input  logic [DATA_W-1:0]   in_wdata,
  input  logic [DATA_W/8-1:0] in_be,
  input  logic [ID_W-1:0]     in_id,
  output logic                mem_req,
  input  logic                mem_gnt,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_we,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic [DATA_W/8-1:0] mem_be,
  input  logic                mem_rvalid,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                ld_valid,
  output logic [DATA_W-1:0]   ld_data,
  output logic                st_done,
  output logic [ID_W-1:0]     rsp_id,
  output logic                proto_err
);
  localparam int BE_W  = DATA_W / 8;
  localparam int ENT_W = ID_W + 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W:0]   DEPTH_L  = (CNT_W + 1)'(DEPTH);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic             granted, accept, pop, q_empty;
  logic [ID_W-1:0]  req_id;
  logic [ENT_W-1:0] q_head;
  logic [CNT_W-1:0] q_count;
  logic [CNT_W:0]   occupancy;

  assign granted   = mem_req && mem_gnt;
  assign occupancy = {1'b0, q_count} + {{CNT_W{1'b0}}, mem_req};
  assign in_ready  = (!mem_req || mem_gnt) && (occupancy < DEPTH_L);
  assign accept    = in_valid && in_ready;

  lsu_req_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W), .ID_W(ID_W)
  ) i_req (
    .clk(clk), .rst(rst), .load_i(accept), .gnt_i(mem_gnt),
    .store_i(in_store), .addr_i(in_addr), .wdata_i(in_wdata),
    .be_i(in_be), .id_i(in_id),
    .req_o(mem_req), .we_o(mem_we), .addr_o(mem_addr),
    .wdata_o(mem_wdata), .be_o(mem_be), .id_o(req_id)
  );

  lsu_inflight_fifo #(.W(ENT_W), .DEPTH(DEPTH)) i_fifo (
    .clk(clk), .rst(rst),
    .push_i(granted), .data_i({mem_we, req_id}),
    .pop_i(pop), .head_o(q_head), .empty_o(q_empty), .count_o(q_count)
  );

  lsu_rsp_stage #(.DATA_W(DATA_W), .ID_W(ID_W)) i_rsp (
    .clk(clk), .rst(rst),
    .rvalid_i(mem_rvalid), .rdata_i(mem_rdata),
    .empty_i(q_empty), .head_i(q_head), .pop_o(pop),
    .ld_valid_o(ld_valid), .ld_data_o(ld_data), .st_done_o(st_done),
    .rsp_id_o(rsp_id), .err_o(proto_err)
  );

  // R2
  accept_issue_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> mem_req);
  // R5
  req_room_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (q_count != FULL_CNT));
endmodule

// File: tb/test_lsu_mem_port.sv
module test_lsu_mem_port;
  localparam int AW = 32, DW = 32, IW = 4, DEPTH = 3, BW = DW / 8;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 0, in_ready, in_store = 0;
  logic [AW-1:0] in_addr = '0;
  logic [DW-1:0] in_wdata = '0;
  logic [BW-1:0] in_be = '0;
  logic [IW-1:0] in_id = '0;
  logic mem_req, mem_gnt = 0, mem_we, mem_rvalid = 0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata = '0, ld_data;
  logic [BW-1:0] mem_be;
  logic ld_valid, st_done, proto_err;
  logic [IW-1:0] rsp_id;

  always #5 clk = ~clk;

  lsu_mem_port #(.ADDR_W(AW), .DATA_W(DW), .ID_W(IW), .DEPTH(DEPTH)) i_lsu_mem_port (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_store(in_store), .in_addr(in_addr), .in_wdata(in_wdata),
    .in_be(in_be), .in_id(in_id), .mem_req(mem_req), .mem_gnt(mem_gnt),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .ld_valid(ld_valid), .ld_data(ld_data), .st_done(st_done),
    .rsp_id(rsp_id), .proto_err(proto_err)
  );

  int compared = 0, mismatched = 0, cyc = 0, stalls = 0, full_seen = 0;
  bit done = 0;

  typedef struct { bit st; logic [IW-1:0] id; } ent_t;
  ent_t mq[$];
  int pend[$];
  int last_due = 0;

  bit m_req = 0, m_we = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_wdata = '0;
  logic [BW-1:0] m_be = '0;
  logic [IW-1:0] m_id = '0;
  bit e_ld = 0, e_st = 0, e_err = 0, e_both = 0;
  logic [DW-1:0] e_data = '0;
  logic [IW-1:0] e_id = '0;
  logic [IW-1:0] next_id = '0;

  function automatic void chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endfunction

  task automatic do_reset();
    rst = 1; in_valid = 0; mem_gnt = 0; mem_rvalid = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(mem_req === 1'b0, "R1 mem_req", mem_req, 0);
    chk(ld_valid === 1'b0, "R1 ld_valid", ld_valid, 0);
    chk(st_done === 1'b0, "R1 st_done", st_done, 0);
    chk(proto_err === 1'b0, "R1 proto_err", proto_err, 0);
    chk(ld_data === '0, "R1 ld_data", ld_data, 0);
    chk(rsp_id === '0, "R1 rsp_id", rsp_id, 0);
    chk(in_ready === 1'b1, "R1 in_ready", in_ready, 1);
    mq.delete(); pend.delete(); last_due = 0;
    m_req = 0; e_ld = 0; e_st = 0; e_err = 0; e_both = 0; e_data = '0; e_id = '0;
    rst = 0;
  endtask

  // one cycle, entered and left at a falling edge
  task automatic step(int vp, int gp, int dmin, int dmax, bit spur);
    bit exp_ready, gnt_now, rv_now;
    logic [DW-1:0] rd;
    chk(mem_req === m_req, "R2 mem_req", mem_req, m_req);
    if (m_req) begin
      chk(mem_addr === m_addr, "R3 mem_addr", mem_addr, m_addr);
      chk(mem_we === m_we, "R2 mem_we", mem_we, m_we);
      chk(mem_wdata === m_wdata, "R3 mem_wdata", mem_wdata, m_wdata);
      chk(mem_be === m_be, "R3 mem_be", mem_be, m_be);
    end
    chk(ld_valid === e_ld, "R6 ld_valid", ld_valid, e_ld);
    chk(st_done === e_st, "R7 st_done", st_done, e_st);
    chk(proto_err === e_err, "R9 proto_err", proto_err, e_err);
    chk(ld_data === e_data, e_st ? "R7 ld_data held" : "R6 ld_data", ld_data, e_data);
    chk(rsp_id === e_id, e_both ? "R8 rsp_id" : "R6 rsp_id", rsp_id, e_id);

    in_valid = ($urandom_range(99) < vp);
    in_store = $urandom_range(1);
    in_addr  = $urandom;
    in_wdata = $urandom;
    in_be    = BW'($urandom);
    in_id    = next_id;
    gnt_now  = mem_req && ($urandom_range(99) < gp);
    rv_now   = spur || (pend.size() > 0 && pend[0] <= cyc);
    rd       = $urandom;
    mem_gnt = gnt_now; mem_rvalid = rv_now; mem_rdata = rd;
    #1;
    exp_ready = (!m_req || gnt_now) && (mq.size() + int'(m_req) < DEPTH);
    if (mq.size() + int'(m_req) >= DEPTH) full_seen++;
    chk(in_ready === exp_ready, (mq.size() + int'(m_req) >= DEPTH) ? "R5 in_ready" : "R4 in_ready",
        in_ready, exp_ready);
    if (in_valid && !exp_ready) stalls++;

    e_ld = 0; e_st = 0; e_err = 0;
    e_both = rv_now && gnt_now;
    if (rv_now) begin
      if (pend.size() > 0) void'(pend.pop_front());
      if (mq.size() > 0) begin
        ent_t e = mq.pop_front();
        e_id = e.id;
        if (e.st) e_st = 1; else begin e_ld = 1; e_data = rd; end
      end else e_err = 1;
    end
    if (m_req && gnt_now) begin
      int d = cyc + $urandom_range(dmax, dmin);
      if (d < last_due) d = last_due;
      last_due = d;
      mq.push_back('{st: m_we, id: m_id});
      pend.push_back(d);
    end
    if (in_valid && exp_ready) begin
      m_req = 1; m_we = in_store; m_addr = in_addr; m_wdata = in_wdata;
      m_be = in_be; m_id = in_id; next_id = next_id + 1'b1;
    end else if (gnt_now) m_req = 0;

    @(posedge clk);
    cyc++;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // R4: same-cycle grants and one-cycle responses run at full rate (R8 push+pop)
    stalls = 0;
    repeat (200) step(100, 100, 1, 1, 0);
    chk(stalls == 0, "R4 one per cycle", stalls, 0);
    // mixed random traffic
    repeat (400) step(60, 50, 1, 6, 0);
    // R5: slow responses fill the queue
    full_seen = 0;
    repeat (200) step(100, 100, 6, 10, 0);
    chk(full_seen > 0, "R5 queue reached full", full_seen, 1);
    // drain, then a response with nothing in flight (R9)
    for (int k = 0; k < 200 && (mq.size() > 0 || pend.size() > 0 || m_req); k++)
      step(0, 100, 1, 2, 0);
    step(0, 0, 1, 1, 1);
    step(0, 0, 1, 1, 0);
    // R1: reset in flight empties the queue, so a later response is an error
    repeat (10) step(100, 100, 8, 8, 0);
    do_reset();
    step(0, 0, 1, 1, 1);
    step(0, 0, 1, 1, 0);
    repeat (300) step(70, 70, 1, 4, 0);
    step(0, 0, 1, 1, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule